// File: doc/BRIEF.md
# ULPI Register Viewport Controller

This block gives a processor access to the internal registers of an external ULPI transceiver through one 32-bit control/status word. Software writes the target register address, the direction and, for a write, the data byte. It then sets a launch bit and polls that bit until it reads back clear. A second launch bit wakes the link out of a low-power state. The word also holds the byte returned by the last register read and a flag that shows whether the link is in its normal synchronous mode.

On the link side the block builds the ULPI register-access sequence itself. It sends the command byte and holds it until the transceiver accepts it. It then either sends the data byte and a stop cycle, or releases the bus for the turnaround and collects the returned byte. If the transceiver takes the bus before it has accepted the command, the block backs off and sends the command again. For a wake-up it holds the stop line until the transceiver gives up the bus. The block tracks low-power entry from the register writes it performs itself: a completed write that clears the suspend control bit takes the link out of synchronous mode.

Top module: `ulpi_viewport`

## Requirements
- R1: Writing 1 to bit 30 starts a register transaction, and writing 0 there has no effect. Bit 30 reads 1 from the cycle after the launching write until the transaction ends, and then reads 0.
- R2: Writing 1 to bit 31 starts a wake-up. Bit 31 reads 1 while the wake-up runs. When bits 31 and 30 are both set in one write, only the wake-up starts and bit 30 stays 0.
- R3: A write that sets bit 30 or bit 31 while either operation is busy starts nothing. The running operation carries on with the address, direction and data it was launched with.
- R4: Bits 23:16 (address), 7:0 (write data) and 29 (direction, 1 = PHY write, 0 = PHY read) reset to 0. Every register write updates them, even while an operation is busy, and they read back unchanged.
- R5: A read puts the command byte {2'b11, addr[5:0]} on the link data output and holds it until NXT is sampled high. The next cycle is the turnaround. In the cycle after that the byte on the link data input is captured into bits 15:8. Bit 30 clears on the first cycle in which DIR is sampled low after the capture.
- R6: A write puts the command byte {2'b10, addr[5:0]} on the data output until NXT is sampled high. The data byte is then driven for exactly one cycle, STP is high for the following cycle, and bit 30 clears after that STP cycle.
- R7: If DIR is sampled high while the command byte is waiting for NXT, the block drives 0x00 and waits until DIR is sampled low. It then drives the same command byte again.
- R8: A wake-up holds STP high until DIR is sampled low. It then clears bit 31 and sets bit 27 to 1.
- R9: Bit 27 resets to 1. It becomes 0 when a register write completes that either targets address 0x04 with data bit 6 at 0, or targets address 0x06 with data bit 6 at 1.
- R10: Bits 28 and 26:24 always read 0, whatever was written to them.
- R11: The data output enable equals the inverse of DIR. When no byte is due on the link, the data output is 0x00 and STP is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the ULPI link |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe, one cycle per write |
| csr_wdata | input | 32 | Register write value |
| csr_rdata | output | 32 | Register read value |
| ulpi_data_in | input | 8 | Byte driven by the transceiver |
| ulpi_data_out | output | 8 | Byte driven by this block |
| ulpi_data_oe | output | 1 | High when this block owns the data bus |
| ulpi_dir | input | 1 | Bus direction from the transceiver, high when it owns the bus |
| ulpi_nxt | input | 1 | Transceiver accept/throttle strobe |
| ulpi_stp | output | 1 | Stop line to the transceiver |

## Verification
The bench aims at four corner cases. The first is a command held for several cycles before NXT; a design that advanced early would send a byte the PHY never accepted. The second is DIR rising before acceptance; a design that missed it would keep driving against the transceiver, or would never resend the command. The third is launch writes during a busy transaction, including a write with both start bits set. A design that let them through would change the address on the wire or would run a wake-up in the middle of a read. The fourth is the pair of writes that enter low power, followed by a wake-up. A wrong design would leave bit 27 high, release STP before DIR falls, or clear bit 31 early.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;

  localparam int CSR_W   = 32;
  localparam int LINK_W  = 8;
  localparam int SADDR_W = 6;

  localparam int B_WAKE = 31;
  localparam int B_RUN  = 30;
  localparam int B_DIR  = 29;
  localparam int B_SYNC = 27;
  localparam int ADDR_LO = 16;
  localparam int RDB_LO  = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_WDATA,
    S_STOP,
    S_TURN,
    S_RDATA,
    S_WDIR,
    S_ABORT,
    S_WAKE
  } seq_state_e;

  // Register command byte: 2'b10 for write, 2'b11 for read, short address below
  function automatic logic [LINK_W-1:0] reg_cmd(input logic is_write,
                                                input logic [LINK_W-1:0] addr);
    return {1'b1, ~is_write, addr[SADDR_W-1:0]};
  endfunction

  // True when a completed PHY write turns the suspend control bit off
  function automatic logic enters_low_power(input logic [LINK_W-1:0] addr,
                                            input logic [LINK_W-1:0] data,
                                            input logic [LINK_W-1:0] set_addr,
                                            input logic [LINK_W-1:0] clr_addr,
                                            input int              sus_bit);
    return ((addr == set_addr) && !data[sus_bit]) ||
           ((addr == clr_addr) &&  data[sus_bit]);
  endfunction

  function automatic logic [CSR_W-1:0] pack_status(input logic wake_busy,
                                                   input logic run_busy,
                                                   input logic is_write,
                                                   input logic sync_ok,
                                                   input logic [LINK_W-1:0] addr,
                                                   input logic [LINK_W-1:0] rd_byte,
                                                   input logic [LINK_W-1:0] wr_byte);
    logic [CSR_W-1:0] w;
    w = '0;
    w[B_WAKE] = wake_busy;
    w[B_RUN]  = run_busy;
    w[B_DIR]  = is_write;
    w[B_SYNC] = sync_ok;
    w[ADDR_LO +: LINK_W] = addr;
    w[RDB_LO  +: LINK_W] = rd_byte;
    w[0 +: LINK_W]       = wr_byte;
    return w;
  endfunction

endpackage

// File: rtl/ulpi_vp_csr.sv
module ulpi_vp_csr
  import ulpi_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wdata,
  input  logic              txn_busy,
  input  logic              wake_busy,
  input  logic              sync_ok,
  input  logic              cap_en,
  input  logic [LINK_W-1:0] cap_byte,
  output logic              start_txn,
  output logic              start_wake,
  output logic [LINK_W-1:0] cmd_addr,
  output logic [LINK_W-1:0] cmd_data,
  output logic              cmd_write,
  output logic [CSR_W-1:0]  rdata
);

  logic [LINK_W-1:0] addr_q, wbyte_q, rbyte_q;
  logic              dir_q;
  logic              idle;
  logic              unused_wbits;

  assign idle       = !txn_busy && !wake_busy;
  // Wake-up wins when both launch bits arrive together
  assign start_wake = wr_en && wdata[B_WAKE] && idle;
  assign start_txn  = wr_en && wdata[B_RUN] && !wdata[B_WAKE] && idle;

  assign cmd_addr  = wdata[ADDR_LO +: LINK_W];
  assign cmd_data  = wdata[0 +: LINK_W];
  assign cmd_write = wdata[B_DIR];

  assign unused_wbits = ^{wdata[28], wdata[26:24], wdata[RDB_LO +: LINK_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wbyte_q <= '0;
      dir_q   <= 1'b0;
    end else if (wr_en) begin
      addr_q  <= wdata[ADDR_LO +: LINK_W];
      wbyte_q <= wdata[0 +: LINK_W];
      dir_q   <= wdata[B_DIR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rbyte_q <= '0;
    else if (cap_en) rbyte_q <= cap_byte;
  end

  assign rdata = pack_status(wake_busy, txn_busy, dir_q, sync_ok,
                             addr_q, rbyte_q, wbyte_q);

  // R5: captured byte appears in the read-data field one cycle later
  a_r5_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (rdata[RDB_LO +: LINK_W] == $past(cap_byte)));

  // R4: field write is visible on the next cycle
  a_r4_field_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[ADDR_LO +: LINK_W] == $past(wdata[ADDR_LO +: LINK_W])));

  // R10: reserved bits never read back set
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[28] == 1'b0) && (rdata[26:24] == 3'b000));

endmodule

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
#(
  parameter logic [LINK_W-1:0] FCTL_ADDR     = 8'h04,
  parameter logic [LINK_W-1:0] FCTL_CLR_ADDR = 8'h06,
  parameter int                SUSPEND_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_txn,
  input  logic              start_wake,
  input  logic [LINK_W-1:0] cmd_addr,
  input  logic [LINK_W-1:0] cmd_data,
  input  logic              cmd_write,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [LINK_W-1:0] ulpi_data_in,
  output logic [LINK_W-1:0] ulpi_data_out,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp,
  output logic              txn_busy,
  output logic              wake_busy,
  output logic              sync_ok,
  output logic              cap_en,
  output logic [LINK_W-1:0] cap_byte
);

  seq_state_e        state, state_nx;
  logic [LINK_W-1:0] l_addr, l_data;
  logic              l_write;
  logic              sync_q;

  // Named events for checks
  logic ev_abort, ev_accept, ev_txn_done, ev_wake_done, ev_lp_entry;

  assign ev_abort     = (state == S_CMD) && ulpi_dir;
  assign ev_accept    = (state == S_CMD) && !ulpi_dir && ulpi_nxt;
  assign ev_txn_done  = (state == S_STOP) || ((state == S_WDIR) && !ulpi_dir);
  assign ev_wake_done = (state == S_WAKE) && !ulpi_dir;
  assign ev_lp_entry  = (state == S_STOP) &&
                        enters_low_power(l_addr, l_data, FCTL_ADDR,
                                         FCTL_CLR_ADDR, SUSPEND_BIT);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: begin
        if (start_wake)     state_nx = S_WAKE;
        else if (start_txn) state_nx = S_CMD;
      end
      S_CMD: begin
        if (ev_abort)       state_nx = S_ABORT;
        else if (ev_accept) state_nx = l_write ? S_WDATA : S_TURN;
      end
      S_WDATA: state_nx = S_STOP;
      S_STOP:  state_nx = S_IDLE;
      S_TURN:  state_nx = S_RDATA;
      S_RDATA: state_nx = S_WDIR;
      S_WDIR:  if (!ulpi_dir) state_nx = S_IDLE;
      S_ABORT: if (!ulpi_dir) state_nx = S_CMD;
      S_WAKE:  if (!ulpi_dir) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  // Command fields frozen at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_addr  <= '0;
      l_data  <= '0;
      l_write <= 1'b0;
    end else if ((state == S_IDLE) && start_txn && !start_wake) begin
      l_addr  <= cmd_addr;
      l_data  <= cmd_data;
      l_write <= cmd_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sync_q <= 1'b1;
    else if (ev_wake_done) sync_q <= 1'b1;
    else if (ev_lp_entry)  sync_q <= 1'b0;
  end

  always_comb begin
    unique case (state)
      S_CMD:   ulpi_data_out = reg_cmd(l_write, l_addr);
      S_WDATA: ulpi_data_out = l_data;
      default: ulpi_data_out = '0;
    endcase
  end

  assign ulpi_stp     = (state == S_STOP) || (state == S_WAKE);
  assign ulpi_data_oe = !ulpi_dir;
  assign txn_busy     = (state != S_IDLE) && (state != S_WAKE);
  assign wake_busy    = (state == S_WAKE);
  assign sync_ok      = sync_q;
  assign cap_en       = (state == S_RDATA);
  assign cap_byte     = ulpi_data_in;

  // R1: busy stays up until the transaction's closing cycle
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_busy && !ev_txn_done) |=> txn_busy);

  // R2: never both operations at once
  a_r2_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_busy && wake_busy));

  // R3: launch decode from the register side is silent while busy
  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_busy || wake_busy) |-> !(start_txn || start_wake));

  // R5: command byte held steady while unaccepted
  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_CMD) && !ulpi_dir && !ulpi_nxt) |=> $stable(ulpi_data_out));

  // R6: stop follows the single data cycle, busy still shown
  a_r6_stp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA) |=> (ulpi_stp && txn_busy));

  // R7: after an abort the bus carries no command until DIR drops
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (ulpi_data_out == '0));

  // R8: wake-up drives STP throughout
  a_r8_wake_stp: assert property (@(posedge clk) disable iff (!rst_n)
    wake_busy |-> ulpi_stp);

  // R8: wake completion restores synchronous mode
  a_r8_wake_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake_done |=> (sync_ok && !wake_busy));

endmodule

// File: rtl/ulpi_viewport.sv
module ulpi_viewport
  import ulpi_vp_pkg::*;
#(
  parameter logic [7:0] FCTL_ADDR     = 8'h04,
  parameter logic [7:0] FCTL_CLR_ADDR = 8'h06,
  parameter int         SUSPEND_BIT   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr_en,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [7:0]  ulpi_data_in,
  output logic [7:0]  ulpi_data_out,
  output logic        ulpi_data_oe,
  input  logic        ulpi_dir,
  input  logic        ulpi_nxt,
  output logic        ulpi_stp
);

  logic              start_txn, start_wake;
  logic [LINK_W-1:0] cmd_addr, cmd_data;
  logic              cmd_write;
  logic              txn_busy, wake_busy, sync_ok, cap_en;
  logic [LINK_W-1:0] cap_byte;

  ulpi_vp_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (csr_wr_en),
    .wdata      (csr_wdata),
    .txn_busy   (txn_busy),
    .wake_busy  (wake_busy),
    .sync_ok    (sync_ok),
    .cap_en     (cap_en),
    .cap_byte   (cap_byte),
    .start_txn  (start_txn),
    .start_wake (start_wake),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cmd_write  (cmd_write),
    .rdata      (csr_rdata)
  );

  ulpi_vp_seq #(
    .FCTL_ADDR     (FCTL_ADDR),
    .FCTL_CLR_ADDR (FCTL_CLR_ADDR),
    .SUSPEND_BIT   (SUSPEND_BIT)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_txn     (start_txn),
    .start_wake    (start_wake),
    .cmd_addr      (cmd_addr),
    .cmd_data      (cmd_data),
    .cmd_write     (cmd_write),
    .ulpi_dir      (ulpi_dir),
    .ulpi_nxt      (ulpi_nxt),
    .ulpi_data_in  (ulpi_data_in),
    .ulpi_data_out (ulpi_data_out),
    .ulpi_data_oe  (ulpi_data_oe),
    .ulpi_stp      (ulpi_stp),
    .txn_busy      (txn_busy),
    .wake_busy     (wake_busy),
    .sync_ok       (sync_ok),
    .cap_en        (cap_en),
    .cap_byte      (cap_byte)
  );

endmodule

// File: tb/ulpi_viewport_bench.sv
module ulpi_viewport_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        oe;
  logic        dir = 1'b0;
  logic        nxt = 1'b0;
  logic        stp;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulpi_viewport u_ulpi_viewport (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(wr_en), .csr_wdata(wdata),
    .csr_rdata(rdata), .ulpi_data_in(din), .ulpi_data_out(dout),
    .ulpi_data_oe(oe), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_stp(stp)
  );

  // Reference model: phase 0 idle, 1 command, 2 data, 3 stop, 4 turnaround,
  // 5 capture, 6 wait-dir, 7 backed-off, 8 wake
  int         ph;
  logic [7:0] m_addr, m_dw, m_rd, k_addr, k_dw;
  logic       m_rw, k_rw, m_ss;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_addr = 0; m_dw = 0; m_rd = 0; m_rw = 0; m_ss = 1;
      k_addr = 0; k_dw = 0; k_rw = 0;
    end else begin
      int was;
      was = ph;
      case (was)
        1: if (dir) ph = 7; else if (nxt) ph = k_rw ? 2 : 4;
        2: ph = 3;
        3: begin
             ph = 0;
             if ((k_addr == 8'd4 && !k_dw[6]) || (k_addr == 8'd6 && k_dw[6])) m_ss = 0;
           end
        4: ph = 5;
        5: begin m_rd = din; ph = 6; end
        6: if (!dir) ph = 0;
        7: if (!dir) ph = 1;
        8: if (!dir) begin ph = 0; m_ss = 1; end
        default: ;
      endcase
      if (wr_en) begin
        m_addr = wdata[23:16]; m_dw = wdata[7:0]; m_rw = wdata[29];
        if (was == 0) begin
          if (wdata[31]) ph = 8;
          else if (wdata[30]) begin
            ph = 1; k_addr = wdata[23:16]; k_dw = wdata[7:0]; k_rw = wdata[29];
          end
        end
      end
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = 0;
    w[31] = (ph == 8);
    w[30] = (ph >= 1 && ph <= 7);
    w[29] = m_rw;
    w[27] = m_ss;
    w[23:16] = m_addr;
    w[15:8]  = m_rd;
    w[7:0]   = m_dw;
    return w;
  endfunction

  function automatic logic [7:0] model_bus();
    if (ph == 1) return (k_rw ? 8'h80 : 8'hC0) + {2'b00, k_addr[5:0]};
    if (ph == 2) return k_dw;
    return 8'h00;
  endfunction

  // Per-cycle comparison (R1..R11 observed at the ports)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (rdata !== model_word() || dout !== model_bus() ||
          stp !== (ph == 3 || ph == 8) || oe !== !dir) begin
        n_bad++;
        $display("FAIL cycle R1,R5,R6,R7,R8,R11 rdata=%h/%h dout=%h/%h stp=%b/%b oe=%b/%b",
                 rdata, model_word(), dout, model_bus(), stp, (ph == 3 || ph == 8), oe, !dir);
      end
    end
  end

  task automatic cyc();
    @(negedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    #1;
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] v);
    cyc(); wr_en = 1'b1; wdata = v;
    cyc(); wr_en = 1'b0; wdata = '0;
  endtask

  // Read flow after the command is on the bus: wait, accept, turn, data, dir hold
  task automatic finish_read(input logic [7:0] b);
    cyc(); nxt = 1'b1;
    cyc(); nxt = 1'b0; dir = 1'b1;
    cyc(); din = b;
    cyc(); din = 8'h00;
    chk("R5 busy while DIR high", {31'd0, rdata[30]}, 32'd1);
    cyc(); dir = 1'b0;
    cyc();
    chk("R5 busy cleared", {31'd0, rdata[30]}, 32'd0);
    chk("R5 captured byte", {24'd0, rdata[15:8]}, {24'd0, b});
  endtask

  task automatic finish_write();
    cyc(); nxt = 1'b1;
    cyc(); nxt = 1'b0;
    cyc();
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset word", rdata, 32'h0800_0000);
    chk("R11 reset bus", {23'd0, stp, dout}, 32'd0);
    rst_n = 1'b1;

    // R4, R10: field-only write, zero launch bits
    reg_write(32'h3F5A_FFC3);
    chk("R4 R10 field readback", rdata, 32'h285A_00C3);
    cyc();
    chk("R1 zero launch bits start nothing", {30'd0, rdata[31:30]}, 32'd0);

    // R5: read of 0x12, command held three cycles
    reg_write(32'h4012_0000);
    chk("R1 busy after launch", {31'd0, rdata[30]}, 32'd1);
    chk("R5 read command byte", {24'd0, dout}, 32'h0000_00D2);
    cyc(); cyc();
    chk("R5 command held", {24'd0, dout}, 32'h0000_00D2);
    finish_read(8'h5C);

    // R6: write 0xA7 to 0x16
    reg_write(32'h6016_00A7);
    chk("R6 write command byte", {24'd0, dout}, 32'h0000_0096);
    cyc(); nxt = 1'b1;
    cyc(); nxt = 1'b0;
    chk("R6 data byte", {23'd0, stp, dout}, 32'h0000_00A7);
    cyc();
    chk("R6 stop cycle", {31'd0, stp}, 32'd1);
    chk("R6 busy during stop", {31'd0, rdata[30]}, 32'd1);
    cyc();
    chk("R6 done", {30'd0, stp, rdata[30]}, 32'd0);
    chk("R9 still synchronous", {31'd0, rdata[27]}, 32'd1);

    // R7: DIR rises before acceptance
    reg_write(32'h402A_0000);
    chk("R7 command", {24'd0, dout}, 32'h0000_00EA);
    dir = 1'b1;
    cyc();
    chk("R7 bus released", {23'd0, oe, dout}, 32'd0);
    cyc(); cyc(); dir = 1'b0;
    cyc();
    chk("R7 command reissued", {23'd0, oe, dout}, 32'h0000_01EA);
    finish_read(8'h3B);

    // R3, R2: launch writes while busy
    reg_write(32'h4033_0000);
    reg_write(32'hC077_0000);
    chk("R3 running command kept", {24'd0, dout}, 32'h0000_00F3);
    chk("R4 address updated while busy", {24'd0, rdata[23:16]}, 32'h0000_0077);
    chk("R3 no wake while busy", {31'd0, rdata[31]}, 32'd0);
    reg_write(32'h6055_0000);
    chk("R3 direction change ignored", {24'd0, dout}, 32'h0000_00F3);
    finish_read(8'h81);
    chk("R3 no stray stop", {31'd0, stp}, 32'd0);

    // R9: enter low power through address 0x04
    reg_write(32'h6004_0000);
    finish_write();
    chk("R9 low power entered", {31'd0, rdata[27]}, 32'd0);

    // R8: wake-up with DIR high for a while
    dir = 1'b1;
    reg_write(32'h8000_0000);
    chk("R8 wake busy", {31'd0, rdata[31]}, 32'd1);
    cyc(); cyc();
    chk("R8 STP held", {31'd0, stp}, 32'd1);
    chk("R9 still low power", {31'd0, rdata[27]}, 32'd0);
    dir = 1'b0;
    cyc();
    chk("R8 wake done", {30'd0, rdata[31], stp}, 32'd0);
    chk("R8 sync restored", {31'd0, rdata[27]}, 32'd1);

    // R9: low power through the clear address, R2: both bits set
    reg_write(32'h6006_0040);
    finish_write();
    chk("R9 clear-address entry", {31'd0, rdata[27]}, 32'd0);
    reg_write(32'hC010_0000);
    chk("R2 only wake starts", {30'd0, rdata[31:30]}, 32'd2);
    cyc();
    chk("R2 wake ends, no transaction", {30'd0, rdata[31:30]}, 32'd0);
    chk("R8 sync after short wake", {31'd0, rdata[27]}, 32'd1);

    repeat (3) cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule